// File: doc/BRIEF.md
# PWM Channel with Source-Clock Bypass

This block is a single pulse-width-modulation channel. Its waveform is built from a prescaler, which turns the source clock into a slower tick, and a period counter, which counts ticks through a programmable period. The output is at its active level for the first part of each period and at its inactive level for the rest. Polarity is programmable, so the active level can be high or low. Two registers hold the configuration: a control word and a period word packing the period and duty counts. Both are written through a plain write strobe and can always be read back.

A bypass control routes the undivided source clock straight to the output pin. This gives a clock-rate square wave that the counter path cannot produce. While bypass is set, the enable, gating, polarity and prescaler settings have no influence on the pin. Bypass takes effect the moment the control word changes, and the counter period that was in progress is abandoned.

Top module: `pwmx_channel`

## Requirements
- R1: After reset both registers read as zero and the output rests at the inactive level of the reset polarity, which is high.
- R2: With `rd_sel`=0, `rd_data` returns the control word zero-extended. With `rd_sel`=1 it returns the period word. Writes use `wr_sel` with the same encoding. Control bits: [3:0] prescaler code, [4] enable, [5] clock gate, [6] active-high polarity, [7] bypass. Period word: [31:16] period count, [15:0] duty count.
- R3: With bypass clear, the counter path runs only when enable and clock gate are both set. Otherwise the output holds the inactive level, which is the inverse of bit [6].
- R4: While running with a ratio of R source cycles per tick, period P and duty D, the output in the j-th cycle after the enabling write is active exactly when floor(j/R) mod P < D. A period count of zero acts as one.
- R5: Code 15 divides by 1. The other codes divide by the fixed table 120, 180, 240, 360, 480, 0, 0, 0, 12000, 24000, 36000, 48000, 72000, 0, 0 for codes 0 to 14.
- R6: A code whose ratio is zero (5, 6, 7, 13, 14) stops the waveform and holds the inactive level, even when the channel is enabled.
- R7: With bit [6] set, the output is high during the duty portion. With bit [6] clear, it is low during the duty portion.
- R8: A duty count of zero gives a constant inactive level. A duty count at or above the period count gives a constant active level.
- R9: A period word written while the channel runs takes effect only at the next period boundary. Until then the running period finishes with the old values.
- R10: With bypass set, the output equals the source clock: high while the clock is high, low while it is low. This holds whatever the enable, gate, polarity and prescaler settings are.
- R11: Setting or clearing bypass changes the output source within the same clock phase that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; also the bypass output source |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 period word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Readback select: 0 control word, 1 period word |
| rd_data | output | 32 | Readback of the selected register |
| pwm_out | output | 1 | PWM pin |

## Verification
The checker samples the pin at rising edges. It therefore assumes that the counter-path level changes only at those edges, and it relates only that level to the configuration. With bypass set, the pin follows the clock itself, so no property can inspect it usefully at an edge. Bypass behaviour is left to the stimulus, which probes the pin mid-phase just after each rising and each falling edge. All register writes are driven at falling edges and are released before the next falling edge, so every configuration change lands on exactly one rising edge. The sweep covers polarity, periods from 1 to 6 and duty counts from 0 to 7. Two slow prescaler codes and a reload during a running period are exercised separately.

// File: rtl/pwmx_pkg.sv
// Package: shared control-word layout and the prescaler ratio table.
// Assumes an 8-bit control word; the bit order is what software writes.
package pwmx_pkg;

    localparam int DIV_W = 17;   // wide enough for the 72000 ratio

    typedef struct packed {
        logic       bypass;    // [7] raw clock to pin
        logic       act_high;  // [6] active level is high
        logic       gate;      // [5] clock gate open
        logic       enable;    // [4] channel enable
        logic [3:0] code;      // [3:0] prescaler select
    } pwmx_ctrl_t;

    localparam int CTRL_W = $bits(pwmx_ctrl_t);

    // Map a prescaler code to its divide ratio; zero marks an invalid code.
    function automatic logic [DIV_W-1:0] ratio_of(input logic [3:0] code,
                                                   input bit        has_div1);
        logic [DIV_W-1:0] r;
        case (code)
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            4'd15:   r = has_div1 ? DIV_W'(1) : '0;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmx_regs.sv
// Module: control and period registers with write decode and readback.
// Assumes one write per cycle at most; readback is combinational.
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output pwmx_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  prd,
    output logic [CNT_W-1:0]  dty
);

    // Capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            prd  <= '0;
            dty  <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                prd <= wr_data[DATA_W-1:CNT_W];
                dty <= wr_data[CNT_W-1:0];
            end else begin
                ctrl <= pwmx_ctrl_t'(wr_data[CTRL_W-1:0]);
            end
        end
    end

    // Select the register shown on the readback port.
    always_comb begin
        if (rd_sel) rd_data = {prd, dty};
        else        rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
    end

endmodule

// File: rtl/pwmx_prescale.sv
// Module: turns the source clock into one tick every RATIO cycles.
// Assumes ratio is nonzero whenever run is high; restarts while idle.
module pwmx_prescale
    import pwmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic [DIV_W-1:0] div_cnt
);

    // A tick fires on the last cycle of each division window.
    assign tick = run && (div_cnt == ratio - DIV_W'(1));

    // Advance the division counter, clearing it on a tick or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_cnt <= '0;
        else if (!run || tick) div_cnt <= '0;
        else                   div_cnt <= div_cnt + DIV_W'(1);
    end

endmodule

// File: rtl/pwmx_wavegen.sv
// Module: period counter with shadowed period/duty, giving the active phase.
// Assumes a new shadow value is picked up only at a period boundary or idle.
module pwmx_wavegen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] shd_prd,
    input  logic [CNT_W-1:0] shd_dty,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_prd,
    output logic [CNT_W-1:0] act_dty
);

    logic [CNT_W-1:0] eff_prd;
    logic             last;

    // A zero period behaves as a one-tick period.
    assign eff_prd = (act_prd == '0) ? CNT_W'(1) : act_prd;
    assign last    = (cnt >= eff_prd - CNT_W'(1));

    // Count ticks through the period and reload shadow values at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_prd <= '0;
            act_dty <= '0;
        end else if (!run) begin
            cnt     <= '0;
            act_prd <= shd_prd;
            act_dty <= shd_dty;
        end else if (tick) begin
            if (last) begin
                cnt     <= '0;
                act_prd <= shd_prd;
                act_dty <= shd_dty;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Active during the first act_dty ticks of the period.
    assign active = run && (cnt < act_dty);

endmodule

// File: rtl/pwmx_channel.sv
// Module: top of one PWM channel; the bypass bit muxes the raw clock to the pin.
// Assumes clk is the source clock and may be used as data for the bypass path.
module pwmx_channel
    import pwmx_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit HAS_DIV1 = 1'b1,
    localparam int DATA_W  = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    pwmx_ctrl_t       ctrl;
    logic [CNT_W-1:0] prd, dty;
    logic [DIV_W-1:0] ratio, div_cnt;
    logic             running, tick, active, level;
    logic [CNT_W-1:0] cnt, act_prd, act_dty;

    pwmx_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ctrl(ctrl), .prd(prd), .dty(dty)
    );

    // Decode the divide ratio and the run condition.
    assign ratio   = ratio_of(ctrl.code, HAS_DIV1);
    assign running = ctrl.enable && ctrl.gate && (ratio != '0);

    pwmx_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .ratio(ratio),
        .tick(tick), .div_cnt(div_cnt)
    );

    pwmx_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .run(running), .tick(tick),
        .shd_prd(prd), .shd_dty(dty), .active(active),
        .cnt(cnt), .act_prd(act_prd), .act_dty(act_dty)
    );

    // Apply polarity, then let bypass override everything.
    assign level   = ctrl.act_high ? active : !active;
    assign pwm_out = ctrl.bypass ? clk : level;

endmodule

// File: rtl/pwmx_channel_chk.sv
// Module: property checker for pwmx_channel, attached by bind.
// Assumes the counter-path level changes only at rising edges.
module pwmx_channel_chk
    import pwmx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass,
    input logic             act_high,
    input logic             running,
    input logic             pwm_out,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_prd,
    input logic [CNT_W-1:0] act_dty,
    input logic [DIV_W-1:0] div_cnt,
    input logic [DIV_W-1:0] ratio
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !running) |-> (pwm_out == !act_high));

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && ratio == '0) |-> (pwm_out == !act_high));

    // R8
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && act_dty == '0) |-> (pwm_out == !act_high));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_prd != '0) |-> (cnt < act_prd));

    // R9
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && cnt != '0) |-> ($stable(act_prd) && $stable(act_dty)));

    // R5
    div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != '0) |-> (div_cnt < ratio));

endmodule

bind pwmx_channel pwmx_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bypass(ctrl.bypass), .act_high(ctrl.act_high),
    .running(running), .pwm_out(pwm_out), .cnt(cnt), .act_prd(act_prd),
    .act_dty(act_dty), .div_cnt(div_cnt), .ratio(ratio)
);

// File: tb/sim_pwmx_channel.sv
module sim_pwmx_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pwmx_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctl(logic [3:0] code, bit en, bit gate, bit pol, bit byp);
        return {24'd0, byp, pol, gate, en, code};
    endfunction

    function automatic logic [31:0] exp_lvl(int j, int r, int p, int d, bit pol);
        int pe = (p == 0) ? 1 : p;
        bit a = ((j / r) % pe) < d;
        return {31'd0, pol ? a : !a};
    endfunction

    task automatic run_wave(string req, logic [3:0] code, int r, int p, int d, bit pol, int n);
        wr(1'b0, ctl(code, 1'b0, 1'b1, pol, 1'b0));
        wr(1'b1, {p[15:0], d[15:0]});
        wr(1'b0, ctl(code, 1'b1, 1'b1, pol, 1'b0));
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(req, {31'd0, pwm_out}, exp_lvl(j, r, p, d, pol));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_sel = 1'b0; #1 chk("R1 ctrl", rd_data, 32'd0);
        rd_sel = 1'b1; #1 chk("R1 period", rd_data, 32'd0);
        chk("R1 pin", {31'd0, pwm_out}, 32'd1);

        // R2 readback
        wr(1'b1, {16'd5, 16'd2});
        wr(1'b0, ctl(4'd15, 1'b0, 1'b1, 1'b1, 1'b0));
        rd_sel = 1'b0; #1 chk("R2 ctrl", rd_data, 32'h6F);
        rd_sel = 1'b1; #1 chk("R2 period", rd_data, {16'd5, 16'd2});

        // R3 enable and gate both needed
        wr(1'b1, {16'd4, 16'd4});
        wr(1'b0, ctl(4'd15, 1'b0, 1'b1, 1'b1, 1'b0));
        for (int j = 0; j < 10; j++) begin
            @(negedge clk); chk("R3 no enable", {31'd0, pwm_out}, 32'd0);
        end
        wr(1'b0, ctl(4'd15, 1'b1, 1'b0, 1'b1, 1'b0));
        for (int j = 0; j < 10; j++) begin
            @(negedge clk); chk("R3 no gate", {31'd0, pwm_out}, 32'd0);
        end
        wr(1'b0, ctl(4'd15, 1'b1, 1'b1, 1'b1, 1'b0));
        @(negedge clk); chk("R3 both set", {31'd0, pwm_out}, 32'd1);

        // R4 R7 R8 sweep over polarity, period and duty at divide-by-1
        for (int pol = 0; pol < 2; pol++)
            for (int p = 1; p <= 6; p++)
                for (int d = 0; d <= 7; d++)
                    run_wave("R4 R7 R8 sweep", 4'd15, 1, p, d, pol[0], 2 * p + 3);

        // R4 zero period behaves as one
        run_wave("R4 zero period", 4'd15, 1, 0, 1, 1'b1, 5);

        // R5 table ratios
        run_wave("R5 code0", 4'd0, 120, 3, 1, 1'b1, 400);
        run_wave("R5 code8", 4'd8, 12000, 2, 1, 1'b1, 12010);

        // R6 invalid codes hold inactive
        run_wave("R6 code5", 4'd5, 1, 4, 0, 1'b1, 300);
        wr(1'b1, {16'd4, 16'd4});
        wr(1'b0, ctl(4'd13, 1'b1, 1'b1, 1'b1, 1'b0));
        for (int j = 0; j < 300; j++) begin
            @(negedge clk); chk("R6 code13", {31'd0, pwm_out}, 32'd0);
        end

        // R9 reload only at the period boundary
        begin
            int ph = 0, cp = 4, cd = 1, sp = 4, sd = 1;
            wr(1'b0, ctl(4'd15, 1'b0, 1'b1, 1'b1, 1'b0));
            wr(1'b1, {16'd4, 16'd1});
            wr(1'b0, ctl(4'd15, 1'b1, 1'b1, 1'b1, 1'b0));
            for (int j = 0; j < 30; j++) begin
                @(negedge clk);
                chk("R9 reload", {31'd0, pwm_out}, {31'd0, ph < cd});
                if (j == 6) begin
                    wr_en = 1'b1; wr_sel = 1'b1; wr_data = {16'd6, 16'd3};
                end
                if (j == 7) wr_en = 1'b0;
                if (ph >= cp - 1) begin ph = 0; cp = sp; cd = sd; end
                else ph++;
                if (j == 6) begin sp = 6; sd = 3; end
            end
        end

        // R10 R11 bypass entry, clock follow, exit
        wr(1'b0, ctl(4'd15, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk); chk("R3 idle low-polarity", {31'd0, pwm_out}, 32'd1);
        wr(1'b0, ctl(4'd5, 1'b0, 1'b0, 1'b1, 1'b1));
        #1 chk("R11 enter", {31'd0, pwm_out}, 32'd1);
        rd_sel = 1'b0; #0 chk("R2 bypass bit", rd_data, 32'hC5);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk); #2 chk("R10 clock low", {31'd0, pwm_out}, 32'd0);
            @(posedge clk); #2 chk("R10 clock high", {31'd0, pwm_out}, 32'd1);
        end
        wr(1'b1, {16'd4, 16'd0});
        wr(1'b0, ctl(4'd15, 1'b1, 1'b1, 1'b0, 1'b1));
        for (int j = 0; j < 8; j++) begin
            @(negedge clk); #2 chk("R10 running low", {31'd0, pwm_out}, 32'd0);
            @(posedge clk); #2 chk("R10 running high", {31'd0, pwm_out}, 32'd1);
        end
        wr(1'b0, ctl(4'd15, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk); #2 chk("R11 exit low phase", {31'd0, pwm_out}, 32'd1);
        @(posedge clk); #2 chk("R11 exit high phase", {31'd0, pwm_out}, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule